// File: doc/BRIEF.md
# Dual 16-bit pattern multiply unit

This block is the execution unit for one SIMD-style multiply instruction. It owns a 16-entry media register file of 32-bit registers. When an instruction strobe arrives, it decodes four register indices and a two-bit pairing mode from the instruction word. It reads the two source registers B and C and treats each as a pair of signed 16-bit halves. It forms two full signed 16x16 products from halves picked by the mode and writes them back. The left product goes to destination A and the right product to destination D.

The whole write-back is gated by an enable bit in the media control register word, which the block receives as an input. When that bit is clear the instruction leaves every register unchanged, but it still completes. A plain load port fills the register file. A combinational read port lets the surrounding pipeline inspect any register.

A two-state controller sequences the unit. In ST_IDLE it waits for a strobe. A strobe in either state takes the transition T_ISSUE to ST_DONE. In ST_DONE the unit raises op_done for one cycle. From ST_DONE it returns to ST_IDLE by T_RETIRE when no new strobe is present, or stays in ST_DONE by T_ISSUE when strobes come back to back.

Top module: `pmul_unit`

## Requirements
- R1: The instruction fields are decoded as follows: destination A index = bits [9:6], source B index = bits [13:10], source C index = bits [17:14], destination D index = bits [21:18], pairing mode = bits [23:22]. Bits [31:24] and [5:0] have no effect.
- R2: Mode 2'b00 gives left = B.high × C.high and right = B.low × C.low. Here high means bits [31:16] and low means bits [15:0].
- R3: Mode 2'b01 gives left = B.low × C.high and right = B.low × C.low.
- R4: Mode 2'b10 gives left = B.high × C.high and right = B.high × C.low.
- R5: Mode 2'b11 gives left = B.low × C.high and right = B.high × C.low.
- R6: Each half is sign-extended. Each product is the full 32-bit two's-complement result, with no truncation or saturation. For example, 0x8000 × 0x8000 = 0x40000000 and 0x8000 × 0x7FFF = 0xC0008000.
- R7: The left product is written to register A and the right product to register D. When A and D name the same register, that register receives the right product.
- R8: When bit 0 of ctl_word is clear, a strobe writes no register, whatever the other bits of ctl_word hold.
- R9: Register 0 always reads as zero, and writes to it from either destination or from the load port are discarded.
- R10: Register contents written by a strobe are visible on rd_data from the cycle after the strobe's clock edge. op_done is high in exactly the cycle after each strobe, whether or not the unit is enabled. Sources are read from the values held before that edge.
- R11: After reset every register reads zero and op_done is low.
- R12: When ld_en is high, ld_data is written to register ld_idx at the clock edge. An instruction write to the same register in the same cycle takes priority over the load. Sources read in that cycle see the value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction strobe, one cycle per instruction |
| op_word | input | 32 | Instruction word |
| ctl_word | input | 32 | Media control register; bit 0 enables write-back |
| ld_en | input | 1 | Load port write enable |
| ld_idx | input | 4 | Load port register index |
| ld_data | input | 32 | Load port data |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | 32 | Read port data (combinational) |
| op_done | output | 1 | Completion pulse, one cycle after each strobe |

## Verification
Each of the four modes is run on the same source pair. The halves carry distinct magnitudes and mixed signs, so picking a wrong half or swapping the left and right products gives a different register value. Extreme halves (0x8000, 0x7FFF, -1) separate full signed products from unsigned, truncated or saturated ones. Disabled strobes with other control bits set, A equal to D, a destination of 0, a source equal to a destination, and a load colliding with a write each isolate one priority or gating rule. A long run of random instructions, loads and enables, compared every cycle against the reference model, catches wrong field positions and back-to-back sequencing errors.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = 4;
    localparam int DEPTH  = 1 << IDX_W;

    localparam int FLD_A_LSB    = 6;
    localparam int FLD_B_LSB    = FLD_A_LSB + IDX_W;
    localparam int FLD_C_LSB    = FLD_B_LSB + IDX_W;
    localparam int FLD_D_LSB    = FLD_C_LSB + IDX_W;
    localparam int FLD_MODE_LSB = FLD_D_LSB + IDX_W;
    localparam int MODE_W       = 2;

    typedef enum logic [MODE_W-1:0] {
        PAIR_HH_LL = 2'b00,
        PAIR_LOW   = 2'b01,
        PAIR_HIGH  = 2'b10,
        PAIR_CROSS = 2'b11
    } pair_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] dst_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] src_c;
        logic [IDX_W-1:0] dst_d;
        pair_mode_t       mode;
    } op_fields_t;

endpackage

// File: rtl/pmul_decode.sv
module pmul_decode
    import pmul_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] op_word,
    output op_fields_t        fields
);

    localparam int TOP_USED = FLD_MODE_LSB + MODE_W;

    logic unused_word_bits;

    always_comb begin
        fields.dst_a = op_word[FLD_A_LSB +: IDX_W];
        fields.src_b = op_word[FLD_B_LSB +: IDX_W];
        fields.src_c = op_word[FLD_C_LSB +: IDX_W];
        fields.dst_d = op_word[FLD_D_LSB +: IDX_W];
        fields.mode  = pair_mode_t'(op_word[FLD_MODE_LSB +: MODE_W]);
    end

    assign unused_word_bits = ^{op_word[WORD_W-1:TOP_USED], op_word[FLD_A_LSB-1:0]};

endmodule

// File: rtl/pmul_datapath.sv
module pmul_datapath
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pair_mode_t        mode,
    input  logic [DATA_W-1:0] b_data,
    input  logic [DATA_W-1:0] c_data,
    output logic [DATA_W-1:0] left_prod,
    output logic [DATA_W-1:0] right_prod
);

    localparam int LANES = 2;

    logic [HALF_W-1:0] b_hi, b_lo, c_hi, c_lo;
    logic              lane_b_high [LANES];
    logic [HALF_W-1:0] lane_c      [LANES];
    logic [DATA_W-1:0] lane_prod   [LANES];

    assign b_hi = b_data[DATA_W-1:HALF_W];
    assign b_lo = b_data[HALF_W-1:0];
    assign c_hi = c_data[DATA_W-1:HALF_W];
    assign c_lo = c_data[HALF_W-1:0];

    // Lane 0 is the left product (always uses C.high),
    // lane 1 is the right product (always uses C.low).
    always_comb begin
        lane_c[0] = c_hi;
        lane_c[1] = c_lo;
        unique case (mode)
            PAIR_HH_LL: begin
                lane_b_high[0] = 1'b1;
                lane_b_high[1] = 1'b0;
            end
            PAIR_LOW: begin
                lane_b_high[0] = 1'b0;
                lane_b_high[1] = 1'b0;
            end
            PAIR_HIGH: begin
                lane_b_high[0] = 1'b1;
                lane_b_high[1] = 1'b1;
            end
            PAIR_CROSS: begin
                lane_b_high[0] = 1'b0;
                lane_b_high[1] = 1'b1;
            end
            default: begin
                lane_b_high[0] = 1'b0;
                lane_b_high[1] = 1'b0;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [HALF_W-1:0]        op_b;
        logic signed [DATA_W-1:0] ext_b;
        logic signed [DATA_W-1:0] ext_c;
        logic signed [DATA_W-1:0] prod;

        assign op_b  = lane_b_high[g] ? b_hi : b_lo;
        assign ext_b = {{HALF_W{op_b[HALF_W-1]}}, op_b};
        assign ext_c = {{HALF_W{lane_c[g][HALF_W-1]}}, lane_c[g]};
        assign prod  = ext_b * ext_c;
        assign lane_prod[g] = prod;

        // R6: sign of a nonzero product follows the operand signs
        a_r6_prod_sign: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_b != '0) && (lane_c[g] != '0)) |->
                (lane_prod[g][DATA_W-1] == (op_b[HALF_W-1] ^ lane_c[g][HALF_W-1])));
    end

    assign left_prod  = lane_prod[0];
    assign right_prod = lane_prod[1];

    // R2..R5: the left lane always multiplies by C.high
    a_r2_left_uses_c_high: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hi == '0) |-> (left_prod == '0));

endmodule

// File: rtl/pmul_regfile.sv
module pmul_regfile
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] rc_data,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic [DATA_W-1:0] rx_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wd_en,
    input  logic [IDX_W-1:0]  wd_idx,
    input  logic [DATA_W-1:0] wd_data,
    input  logic              wl_en,
    input  logic [IDX_W-1:0]  wl_idx,
    input  logic [DATA_W-1:0] wl_data
);

    logic [DEPTH*DATA_W-1:0] store;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [DATA_W-1:0] q;
        if (i == 0) begin : g_zero
            assign q = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wd_en && (wd_idx == IDX_W'(i))) begin
                    q <= wd_data;
                end else if (wa_en && (wa_idx == IDX_W'(i))) begin
                    q <= wa_data;
                end else if (wl_en && (wl_idx == IDX_W'(i))) begin
                    q <= wl_data;
                end
            end
        end
        assign store[i*DATA_W +: DATA_W] = q;
    end

    assign rb_data = store[rb_idx*DATA_W +: DATA_W];
    assign rc_data = store[rc_idx*DATA_W +: DATA_W];
    assign rx_data = store[rx_idx*DATA_W +: DATA_W];

    // R8: without any write request the contents hold
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_en || wd_en || wl_en) |=> $stable(store));

    // R7: D wins when both destinations collide
    a_r7_d_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wd_en && (wa_idx == wd_idx) && (wd_idx != '0)) |=>
            (store[$past(wd_idx)*DATA_W +: DATA_W] == $past(wd_data)));

    // R12: an uncontested load lands
    a_r12_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_en && (wl_idx != '0) && !(wa_en && (wa_idx == wl_idx))
               && !(wd_en && (wd_idx == wl_idx))) |=>
            (store[$past(wl_idx)*DATA_W +: DATA_W] == $past(wl_data)));

endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
    import pmul_pkg::*;
#(
    parameter int CTL_W  = 32,
    parameter int EN_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [31:0]       op_word,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              op_done
);

    ctl_state_t        state_q, state_n;
    op_fields_t        fld;
    logic [DATA_W-1:0] b_val, c_val, left_val, right_val;
    logic              unit_en;
    logic              wr_a, wr_d;
    logic              unused_ctl;

    assign unit_en    = ctl_word[EN_BIT];
    assign unused_ctl = ^ctl_word;

    pmul_decode #(.WORD_W(32)) i_decode (
        .op_word (op_word),
        .fields  (fld)
    );

    pmul_datapath i_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (fld.mode),
        .b_data     (b_val),
        .c_data     (c_val),
        .left_prod  (left_val),
        .right_prod (right_val)
    );

    pmul_regfile i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .rb_idx  (fld.src_b),
        .rb_data (b_val),
        .rc_idx  (fld.src_c),
        .rc_data (c_val),
        .rx_idx  (rd_idx),
        .rx_data (rd_data),
        .wa_en   (wr_a),
        .wa_idx  (fld.dst_a),
        .wa_data (left_val),
        .wd_en   (wr_d),
        .wd_idx  (fld.dst_d),
        .wd_data (right_val),
        .wl_en   (ld_en),
        .wl_idx  (ld_idx),
        .wl_data (ld_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Transitions: T_ISSUE on a strobe, T_RETIRE otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_n = op_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_n = op_valid ? ST_DONE : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        op_done = 1'b0;
        wr_a    = 1'b0;
        wr_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_a = op_valid && unit_en;
                wr_d = op_valid && unit_en;
            end
            ST_DONE: begin
                op_done = 1'b1;
                wr_a    = op_valid && unit_en;
                wr_d    = op_valid && unit_en;
            end
            default: begin
                op_done = 1'b0;
            end
        endcase
    end

    // R10: every strobe completes on the next cycle
    a_r10_done_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> op_done);

    // R10: no completion without a strobe
    a_r10_done_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !op_done);

    // R9: register 0 is never visible as nonzero
    a_r9_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |-> (rd_data == '0));

endmodule

// File: tb/test_pmul_unit.sv
`timescale 1ns/10ps
module test_pmul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_word = '0;
    logic [31:0] ctl_word = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        op_done;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] mdl [16];
    bit finished = 0;

    always #5 clk = ~clk;

    pmul_unit i_pmul_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .ctl_word(ctl_word), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .op_done(op_done)
    );

    function automatic logic [31:0] mk(input logic [1:0] m, input logic [3:0] a,
                                       input logic [3:0] b, input logic [3:0] c,
                                       input logic [3:0] d);
        return {8'hA5, m, d, c, b, a, 6'h2B};
    endfunction

    function automatic int sx(input logic [15:0] h);
        return int'($signed(h));
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sweep(input logic exp_done, input string tag);
        check({31'b0, op_done}, {31'b0, exp_done}, {tag, " R10 done"});
        for (int k = 0; k < 16; k++) begin
            rd_idx = 4'(k);
            #0.2;
            check(rd_data, mdl[k], $sformatf("%s reg%0d", tag, k));
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare after.
    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] c,
                        input logic le, input logic [3:0] li, input logic [31:0] ld,
                        input string tag);
        logic [31:0] nx [16];
        int bh, bl, ch, cl, lp, rp;
        logic [3:0] a, b, cc, d;
        @(negedge clk);
        op_valid = v; op_word = w; ctl_word = c;
        ld_en = le; ld_idx = li; ld_data = ld;
        a = w[9:6]; b = w[13:10]; cc = w[17:14]; d = w[21:18];
        bh = sx(mdl[b][31:16]); bl = sx(mdl[b][15:0]);
        ch = sx(mdl[cc][31:16]); cl = sx(mdl[cc][15:0]);
        case (w[23:22])
            2'd0: begin lp = bh * ch; rp = bl * cl; end
            2'd1: begin lp = bl * ch; rp = bl * cl; end
            2'd2: begin lp = bh * ch; rp = bh * cl; end
            default: begin lp = bl * ch; rp = bh * cl; end
        endcase
        for (int k = 0; k < 16; k++) nx[k] = mdl[k];
        if (le) nx[li] = ld;
        if (v && c[0]) begin
            nx[a] = lp;
            nx[d] = rp;
        end
        nx[0] = '0;
        @(posedge clk);
        for (int k = 0; k < 16; k++) mdl[k] = nx[k];
        #1;
        sweep(v, tag);
    endtask

    task automatic load(input logic [3:0] i, input logic [31:0] val);
        step(1'b0, '0, 32'h1, 1'b1, i, val, "R12 load");
    endtask

    task automatic op(input logic [31:0] w, input logic [31:0] c, input string tag);
        step(1'b1, w, c, 1'b0, '0, '0, tag);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mdl[k] = '0;
        repeat (3) @(posedge clk);
        #1;
        sweep(1'b0, "R11 reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        sweep(1'b0, "R11 after release");

        load(4'd1, 32'h0003_FFFE);
        load(4'd2, 32'hFFF9_0005);
        load(4'd3, 32'h8000_7FFF);
        load(4'd4, 32'h8000_8000);
        load(4'd5, 32'hFFFF_0001);
        load(4'd0, 32'hDEAD_BEEF);   // R9 load to reg 0 discarded

        op(mk(2'b00, 4'd6, 4'd1, 4'd2, 4'd7), 32'h1, "R2 mode00 R1");
        op(mk(2'b01, 4'd8, 4'd1, 4'd2, 4'd9), 32'h1, "R3 mode01");
        op(mk(2'b10, 4'd10, 4'd1, 4'd2, 4'd11), 32'h1, "R4 mode10");
        op(mk(2'b11, 4'd12, 4'd1, 4'd2, 4'd13), 32'h1, "R5 mode11");
        op(mk(2'b00, 4'd6, 4'd4, 4'd4, 4'd7), 32'h1, "R6 8000x8000");
        op(mk(2'b11, 4'd8, 4'd3, 4'd3, 4'd9), 32'h1, "R6 8000x7FFF");
        op(mk(2'b00, 4'd10, 4'd5, 4'd3, 4'd11), 32'h1, "R6 minus one");
        op(mk(2'b00, 4'd14, 4'd1, 4'd2, 4'd15), 32'h0, "R8 disabled");
        op(mk(2'b01, 4'd14, 4'd1, 4'd2, 4'd15), 32'hFFFF_FFFE, "R8 other bits set");
        op(mk(2'b10, 4'd14, 4'd1, 4'd2, 4'd14), 32'h1, "R7 A equals D");
        op(mk(2'b00, 4'd0, 4'd1, 4'd2, 4'd15), 32'h1, "R9 A is reg0");
        op(mk(2'b00, 4'd13, 4'd1, 4'd2, 4'd0), 32'h1, "R9 D is reg0");
        op(mk(2'b11, 4'd1, 4'd1, 4'd2, 4'd2), 32'h1, "R10 sources pre-edge");
        step(1'b1, mk(2'b00, 4'd6, 4'd3, 4'd4, 4'd7), 32'h1, 1'b1, 4'd6,
             32'h1234_5678, "R12 load loses to A");
        step(1'b1, mk(2'b00, 4'd8, 4'd3, 4'd4, 4'd9), 32'h1, 1'b1, 4'd3,
             32'h0002_0002, "R12 load to source");
        step(1'b1, mk(2'b01, 4'd10, 4'd3, 4'd4, 4'd11), 32'h0, 1'b1, 4'd10,
             32'hCAFE_F00D, "R12 load while disabled");
        step(1'b0, '0, 32'h1, 1'b0, '0, '0, "R10 idle");

        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            w = $urandom();
            step(1'($urandom_range(0, 3) != 0), w, {$urandom()} | 32'(($urandom_range(0, 4) != 0) ? 1 : 0),
                 1'($urandom_range(0, 2) == 0), 4'($urandom()), $urandom(), "R1 random");
        end
        step(1'b0, '0, 32'h1, 1'b0, '0, '0, "R10 final idle");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule